// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block turns several reset causes into one microprocessor reset, driven out in both polarities. The causes are a supply-low flag (a comparator result that is already synchronous to the clock), a push-button reset input that is active low, and a single-cycle request from a watchdog whose timer has expired. Reset is held for as long as a level cause is active. Once the last cause has cleared, reset stays asserted for a further fixed timeout, counted in clock cycles.

Any cause that arrives while a timeout is running starts the timeout again from its full length. The push-button input passes through a two-flop synchronizer before the block uses it. Out of power-on the block comes up with reset asserted and the timeout already loaded. The block also drives a single-cycle strobe on the cycle reset is released, and a watchdog can use this strobe to start counting. The timeout is the parameter `TIMEOUT_CYCLES`. Its default is 40,000,000, which is 200 ms at 200 MHz.

Top module: `sup_reset_gen`

## Requirements
- R1: While `por_n` is low, `rst_out_n` is 0. After `por_n` rises between two clock edges, `rst_out_n` stays 0 through the first TIMEOUT_CYCLES-1 rising edges and is 1 after edge TIMEOUT_CYCLES, provided no cause is active.
- R2: At every rising edge where `supply_low` is sampled at 1, `rst_out_n` is 0 after that edge. It remains 0 for as long as `supply_low` stays at 1.
- R3: After the last edge at which `supply_low` was sampled at 1, `rst_out_n` stays 0 for TIMEOUT_CYCLES-1 further edges and goes to 1 at edge TIMEOUT_CYCLES.
- R4: If a cause is sampled while the timeout is running, the release moves to TIMEOUT_CYCLES edges after that sample, wherever the running timeout had reached.
- R5: `man_rst_n` at 0 asserts reset at the third rising edge after the input falls. After the input rises, reset is released at edge TIMEOUT_CYCLES+2, counting the first edge that samples the high level as edge 1.
- R6: If `wdog_expire` is high for a single cycle and sampled at edge e, `rst_out_n` is 0 from edge e and goes to 1 at edge e+TIMEOUT_CYCLES.
- R7: `rst_out` is the bitwise inverse of `rst_out_n` in every cycle.
- R8: `release_stb` is 1 for exactly the one cycle in which `rst_out_n` has just changed from 0 to 1, and it is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on initialisation, active low |
| supply_low | input | 1 | Supply-below-threshold flag, already synchronous |
| man_rst_n | input | 1 | Push-button reset input, active low, asynchronous |
| wdog_expire | input | 1 | Single-cycle watchdog expiry request |
| rst_out_n | output | 1 | Reset output, active low |
| rst_out | output | 1 | Reset output, active high |
| release_stb | output | 1 | Single-cycle pulse on the cycle reset is released |

## Verification
`supply_low` and `wdog_expire` are registered once, so they affect the reset outputs one edge after they are sampled. `man_rst_n` passes through two synchronizer stages first and therefore needs three edges. A release is due exactly TIMEOUT_CYCLES edges after the last cause sample, and the strobe rises on that same edge. The bench drives its inputs on falling edges and counts rising edges to these exact latencies. At each point it samples at the following falling edge, checking the cycle just before a release (still asserted) and the release cycle itself. It sweeps the restart offset over every position inside the timeout and sweeps the hold length of each level cause.

// File: rtl/sup_reset_gen.sv
module sup_reset_gen #(
  parameter int unsigned TIMEOUT_CYCLES = 40_000_000
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_low,
  input  logic man_rst_n,
  input  logic wdog_expire,
  output logic rst_out_n,
  output logic rst_out,
  output logic release_stb
);

  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(TIMEOUT_CYCLES);

  logic [1:0]    mr_sync;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          rst_q;
  logic          cause;

  assign cause   = supply_low | ~mr_sync[1] | wdog_expire;
  assign cnt_nxt = cause ? LOAD : ((cnt != '0) ? cnt - CW'(1) : cnt);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mr_sync     <= 2'b11;
      cnt         <= LOAD;
      rst_q       <= 1'b1;
      release_stb <= 1'b0;
    end else begin
      mr_sync     <= {mr_sync[0], man_rst_n};
      cnt         <= cnt_nxt;
      rst_q       <= (cnt_nxt != '0);
      release_stb <= rst_q & (cnt_nxt == '0);
    end
  end

  assign rst_out_n = ~rst_q;
  assign rst_out   = rst_q;

  // R2: a sampled supply fault leaves reset asserted after the edge
  assert_supply_hold_R2: assert property (@(posedge clk) disable iff (!por_n)
    supply_low |=> !rst_out_n);

  // R5: synchronized push-button level holds reset
  assert_button_hold_R5: assert property (@(posedge clk) disable iff (!por_n)
    !mr_sync[1] |=> !rst_out_n);

  // R6: watchdog request asserts reset
  assert_wdog_reset_R6: assert property (@(posedge clk) disable iff (!por_n)
    wdog_expire |=> !rst_out_n);

  // R3: no release on an edge where any cause was sampled
  assert_clean_release_R3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_out_n) |-> $past(!cause));

  // R8: strobe coincides with a real release and lasts one cycle
  assert_strobe_edge_R8: assert property (@(posedge clk) disable iff (!por_n)
    release_stb |-> (rst_out_n && $past(!rst_out_n)));

  assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!por_n)
    release_stb |=> !release_stb);

endmodule

// File: tb/tb_sup_reset_gen.sv
`timescale 1ns/1ps
module tb_sup_reset_gen;
  localparam int T = 5;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_low = 1'b0;
  logic man_rst_n = 1'b1;
  logic wdog_expire = 1'b0;
  logic rst_out_n, rst_out, release_stb;

  int checks = 0;
  int fails = 0;
  logic prev_n = 1'b0;

  always #2.5 clk = ~clk;

  sup_reset_gen #(.TIMEOUT_CYCLES(T)) dut (
    .clk(clk), .por_n(por_n), .supply_low(supply_low), .man_rst_n(man_rst_n),
    .wdog_expire(wdog_expire), .rst_out_n(rst_out_n), .rst_out(rst_out),
    .release_stb(release_stb)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_rst(input logic exp_n, input string tag);
    check(rst_out_n == exp_n, tag, rst_out_n, exp_n);
  endtask

  // release expected after T edges counted from the last cause sample
  task automatic expect_release(input string tag);
    step(T - 1);
    expect_rst(1'b0, tag);
    check(release_stb == 1'b0, {tag, " R8 early strobe"}, release_stb, 0);
    step(1);
    expect_rst(1'b1, tag);
    check(release_stb == 1'b1, {tag, " R8 strobe"}, release_stb, 1);
    step(1);
    check(release_stb == 1'b0, {tag, " R8 strobe width"}, release_stb, 0);
  endtask

  // R7 and R8 monitored in every cycle
  always @(negedge clk) begin
    if (por_n) begin
      check(rst_out == ~rst_out_n, "R7 complement", rst_out, ~rst_out_n);
      check(release_stb == (rst_out_n & ~prev_n), "R8 strobe vs release", release_stb, rst_out_n & ~prev_n);
    end
    prev_n = rst_out_n;
  end

  initial begin
    @(negedge clk);
    step(2);
    expect_rst(1'b0, "R1 held in por");
    check(rst_out == 1'b1, "R7 in por", rst_out, 1);
    por_n = 1'b1;
    step(T - 1);
    expect_rst(1'b0, "R1 before release");
    step(1);
    expect_rst(1'b1, "R1 release");
    step(2);

    for (int h = 1; h <= 4; h++) begin
      supply_low = 1'b1;
      for (int i = 0; i < h; i++) begin
        step(1);
        expect_rst(1'b0, "R2 supply hold");
      end
      supply_low = 1'b0;
      expect_release("R3 supply timeout");
      step(1);
    end

    for (int k = 1; k < T; k++) begin
      supply_low = 1'b1;
      step(1);
      supply_low = 1'b0;
      step(k);
      expect_rst(1'b0, "R4 mid timeout");
      wdog_expire = 1'b1;
      step(1);
      wdog_expire = 1'b0;
      expect_release("R4 restart");
      step(1);
    end

    for (int h = 1; h <= 3; h++) begin
      man_rst_n = 1'b0;
      step(2);
      expect_rst(1'b1, "R5 sync latency");
      step(1);
      expect_rst(1'b0, "R5 assert");
      step(h);
      man_rst_n = 1'b1;
      step(T + 1);
      expect_rst(1'b0, "R5 before release");
      step(1);
      expect_rst(1'b1, "R5 release");
      step(2);
    end

    wdog_expire = 1'b1;
    step(1);
    wdog_expire = 1'b0;
    expect_rst(1'b0, "R6 wdog assert");
    expect_release("R6 wdog pulse");
    step(3);
    expect_rst(1'b1, "R6 stays released");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog timeout actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule